// File: doc/BRIEF.md
# Converter Conversion Timing and Parallel Bus Port

This block is the digital control side of a four-channel, 12-bit sampling converter. A falling edge on the active-low start input puts the sampler into hold and starts a conversion. The conversion is timed by master-clock ticks, which arrive as a one-cycle enable qualified on the system clock. The ticks may stop between and during conversions, and the counter waits for them. After the thirteenth counted tick the sampler returns to track. One system clock later BUSY drops, and the result word, which the analog side supplies on `result_in`, is captured together with the 2-bit channel tag that was selected when the conversion started.

A parallel port gated by chip-select, read and write strobes gives access to the result and to a small control register. In word mode all 12 result bits are presented at once. In byte mode, data line 8 becomes a high-byte select: the low half gives the low eight result bits, and the high half gives the top four result bits, the channel tag and two zero bits. The control register holds the channel select and an auto-sleep enable. When auto-sleep is set, the block goes to sleep at the end of each conversion and ignores start edges until a rising edge on the start input wakes it.

Top module: `adc_ctl_port`

## Requirements
- R1: After a synchronous active-low reset: `busy`=0, `sample_hold`=0, `asleep`=0, `db_oe`=0, the result and tag registers are 0, and the control register is 0 (channel 0, auto-sleep off).
- R2: When `conv_n` is sampled high on one clock edge and low on the next, and the block is neither busy nor asleep, `busy` and `sample_hold` are both 1 after that second edge.
- R3: During a conversion, only edges with `mclk_tick`=1 advance the count, and the count holds across edges without a tick. `sample_hold` drops at the edge that carries the 13th counted tick. `busy` drops one edge later, and at that same edge `result_in` and the channel latched at start are captured.
- R4: A falling edge on `conv_n` while `busy` is 1 is ignored. The conversion ends on its original schedule.
- R5: With `cs_n`=0, `rd_n`=0 and `wb`=1, `db_out` equals the 12-bit result and `db_oe`=12'hFFF.
- R6: With `cs_n`=0, `rd_n`=0, `wb`=0 and `db_in[8]`=0, `db_out` = {4'b0, result[7:0]} and `db_oe`=12'h0FF.
- R7: With `cs_n`=0, `rd_n`=0, `wb`=0 and `db_in[8]`=1, `db_out[7:0]` = {2'b00, tag[1:0], result[11:8]}, `db_out[11:8]`=0 and `db_oe`=12'h0FF.
- R8: When `cs_n` or `rd_n` is 1, `db_oe`=0 and `db_out`=0.
- R9: A word write (`cs_n`=0, `wr_n`=0, `wb`=1) loads the control register from `db_in`. The channel select is control bits [1:0] and auto-sleep enable is control bit 8.
- R10: In byte mode a write with `db_in[8]`=0 loads control bits [7:0] from `db_in[7:0]`. A write with `db_in[8]`=1 loads control bits [11:8] from `db_in[3:0]` only when `db_in[7:4]`=0, and is ignored otherwise.
- R11: If auto-sleep is enabled when a conversion ends, `asleep` becomes 1 at the edge where `busy` falls. While asleep, falling edges of `conv_n` start nothing. A rising edge of `conv_n` clears `asleep`, and later falling edges start conversions again.
- R12: A write strobe with `cs_n`=1 leaves the control register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mclk_tick | input | 1 | One master-clock rising edge in this cycle |
| conv_n | input | 1 | Active-low conversion start |
| result_in | input | 12 | Conversion result from the analog side |
| wb | input | 1 | 1 = word transfers, 0 = byte transfers |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| db_in | input | 12 | Data lines inward; bit 8 is the high-byte select in byte mode |
| db_out | output | 12 | Data lines outward |
| db_oe | output | 12 | Per-line drive enable; 0 means high impedance |
| busy | output | 1 | Conversion in progress |
| sample_hold | output | 1 | 1 = sampler in hold, 0 = tracking |
| asleep | output | 1 | Block is powered down, waiting for a wake edge |

## Verification
The hardest situations to reach are the tick gaps and the stray start edges during a conversion. If the count restarted or advanced without a tick, the only visible sign would be `busy` falling a few cycles late or early. The stimulus therefore gives each tick a random chance, so gaps of random length separate the ticks. In some conversions it pulses `conv_n` high and low again mid-count, and it checks `busy` and `sample_hold` after every single edge against a bench count of ticks. The sleep path needs a byte-mode control write first, including a high-byte write that is rejected. Its effect is then read back only through the way start edges are handled after the next conversion.

// File: rtl/adc_port_pkg.sv
// Package: shared constants and the read-path selector for the converter port.
// Assumes a byte lane of 8 bits and a control word laid out with the channel
// select in its low bits and the auto-sleep enable at bit 8.
package adc_port_pkg;
    localparam int BYTE_W    = 8;
    localparam int SLEEP_BIT = 8;

    typedef enum logic [1:0] {
        RSEL_OFF  = 2'd0,
        RSEL_WORD = 2'd1,
        RSEL_LO   = 2'd2,
        RSEL_HI   = 2'd3
    } rsel_e;
endpackage

// File: rtl/adc_start_ctl.sv
// Module: start-edge detection and sleep/wake control.
// Registers conv_n once to find edges. A falling edge becomes a start pulse
// only while idle and awake. Sleep is entered when a conversion finishes with
// auto-sleep enabled and left on a rising edge of conv_n.
module adc_start_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_n,
    input  logic busy,
    input  logic finish,
    input  logic sleep_en,
    output logic conv_q,
    output logic start,
    output logic asleep
);
    logic fall_edge;
    logic rise_edge;

    // edge detection from the registered copy of conv_n
    always_comb begin
        fall_edge = conv_q & ~conv_n;
        rise_edge = ~conv_q & conv_n;
        start     = fall_edge & ~busy & ~asleep;
    end

    // delay line for conv_n; resets high (inactive)
    always_ff @(posedge clk) begin
        if (!rst_n) conv_q <= 1'b1;
        else        conv_q <= conv_n;
    end

    // sleep flag: set at conversion end when enabled, cleared by a wake edge
    always_ff @(posedge clk) begin
        if (!rst_n)                 asleep <= 1'b0;
        else if (finish && sleep_en) asleep <= 1'b1;
        else if (asleep && rise_edge) asleep <= 1'b0;
    end
endmodule

// File: rtl/adc_conv_timer.sv
// Module: conversion timer counted in master-clock ticks.
// Assumes ticks arrive as one-cycle enables on clk and may stop at any time.
// The count only moves on a tick. On the last tick hold is released, and one
// clk later finish pulses and busy drops.
module adc_conv_timer #(
    parameter int CONV_EDGES = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic busy,
    output logic hold,
    output logic finish
);
    localparam int CW = $clog2(CONV_EDGES + 1);
    localparam logic [CW-1:0] LAST = CW'(CONV_EDGES - 1);

    logic [CW-1:0] cnt;

    // start, count ticks, release hold on the last one, end one clk later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            busy   <= 1'b0;
            hold   <= 1'b0;
            finish <= 1'b0;
        end else if (start) begin
            cnt    <= '0;
            busy   <= 1'b1;
            hold   <= 1'b1;
            finish <= 1'b0;
        end else if (finish) begin
            busy   <= 1'b0;
            finish <= 1'b0;
        end else if (busy && hold && tick) begin
            if (cnt == LAST) begin
                cnt    <= '0;
                hold   <= 1'b0;
                finish <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/adc_ctrl_reg.sv
// Module: control register written from the parallel port.
// Word mode loads the whole register. Byte mode uses db_in[8] as the
// high-byte select; a high-byte write with a nonzero upper nibble is dropped.
module adc_ctrl_reg #(
    parameter int DATA_W = 12,
    parameter int CH_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              wb,
    input  logic [DATA_W-1:0] db_in,
    output logic [CH_W-1:0]   chan_sel,
    output logic              sleep_en
);
    import adc_port_pkg::*;
    localparam int HI_W = DATA_W - BYTE_W;

    logic [DATA_W-1:0] ctrl_q;
    logic              wr_en;
    logic              hben;
    logic              hi_clean;

    // decode the write strobe and byte-lane checks
    always_comb begin
        wr_en    = ~cs_n & ~wr_n;
        hben     = db_in[BYTE_W];
        hi_clean = (db_in[BYTE_W-1:HI_W] == '0);
    end

    // register update by transfer mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            if (wb)
                ctrl_q <= db_in;
            else if (!hben)
                ctrl_q[BYTE_W-1:0] <= db_in[BYTE_W-1:0];
            else if (hi_clean)
                ctrl_q[DATA_W-1:BYTE_W] <= db_in[HI_W-1:0];
        end
    end

    // field extraction
    always_comb begin
        chan_sel = ctrl_q[CH_W-1:0];
        sleep_en = ctrl_q[SLEEP_BIT];
    end
endmodule

// File: rtl/adc_read_mux.sv
// Module: read path of the parallel port.
// Purely combinational: picks word, low byte or high byte (with channel tag)
// and drives enables only while chip select and read are both low.
module adc_read_mux #(
    parameter int DATA_W = 12,
    parameter int CH_W   = 2
) (
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wb,
    input  logic              hben,
    input  logic [DATA_W-1:0] result,
    input  logic [CH_W-1:0]   tag,
    output logic [DATA_W-1:0] db_out,
    output logic [DATA_W-1:0] db_oe
);
    import adc_port_pkg::*;
    localparam int HI_W  = DATA_W - BYTE_W;
    localparam int PAD_W = BYTE_W - HI_W - CH_W;

    rsel_e             rsel;
    logic [BYTE_W-1:0] hi_byte;

    // choose the read view
    always_comb begin
        if (cs_n || rd_n) rsel = RSEL_OFF;
        else if (wb)      rsel = RSEL_WORD;
        else if (hben)    rsel = RSEL_HI;
        else              rsel = RSEL_LO;
    end

    // assemble the high byte: zero pad, channel tag, top result bits
    always_comb begin
        hi_byte = {{PAD_W{1'b0}}, tag, result[DATA_W-1:BYTE_W]};
    end

    // drive data and per-line enables
    always_comb begin
        db_out = '0;
        db_oe  = '0;
        case (rsel)
            RSEL_WORD: begin
                db_out = result;
                db_oe  = '1;
            end
            RSEL_LO: begin
                db_out[BYTE_W-1:0] = result[BYTE_W-1:0];
                db_oe[BYTE_W-1:0]  = '1;
            end
            RSEL_HI: begin
                db_out[BYTE_W-1:0] = hi_byte;
                db_oe[BYTE_W-1:0]  = '1;
            end
            default: begin
                db_out = '0;
                db_oe  = '0;
            end
        endcase
    end
endmodule

// File: rtl/adc_ctl_port.sv
// Module: top of the converter control block.
// Ties together start/sleep control, the tick-counted timer, the control
// register and the read path. It captures result_in and the channel tag on
// the cycle the timer finishes. Assumes result_in is valid by that cycle.
module adc_ctl_port #(
    parameter int DATA_W     = 12,
    parameter int CH_W       = 2,
    parameter int CONV_EDGES = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mclk_tick,
    input  logic              conv_n,
    input  logic [DATA_W-1:0] result_in,
    input  logic              wb,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] db_in,
    output logic [DATA_W-1:0] db_out,
    output logic [DATA_W-1:0] db_oe,
    output logic              busy,
    output logic              sample_hold,
    output logic              asleep
);
    import adc_port_pkg::*;

    logic              conv_q;
    logic              start;
    logic              finish;
    logic              sleep_en;
    logic [CH_W-1:0]   chan_sel;
    logic [CH_W-1:0]   chan_lat;
    logic [CH_W-1:0]   tag_q;
    logic [DATA_W-1:0] result_q;

    adc_start_ctl u_start (
        .clk      (clk),
        .rst_n    (rst_n),
        .conv_n   (conv_n),
        .busy     (busy),
        .finish   (finish),
        .sleep_en (sleep_en),
        .conv_q   (conv_q),
        .start    (start),
        .asleep   (asleep)
    );

    adc_conv_timer #(.CONV_EDGES(CONV_EDGES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .tick   (mclk_tick),
        .busy   (busy),
        .hold   (sample_hold),
        .finish (finish)
    );

    adc_ctrl_reg #(.DATA_W(DATA_W), .CH_W(CH_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .wr_n     (wr_n),
        .wb       (wb),
        .db_in    (db_in),
        .chan_sel (chan_sel),
        .sleep_en (sleep_en)
    );

    // latch the channel at start; capture result and tag at finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_lat <= '0;
            tag_q    <= '0;
            result_q <= '0;
        end else begin
            if (start)  chan_lat <= chan_sel;
            if (finish) begin
                tag_q    <= chan_lat;
                result_q <= result_in;
            end
        end
    end

    adc_read_mux #(.DATA_W(DATA_W), .CH_W(CH_W)) u_rd (
        .cs_n   (cs_n),
        .rd_n   (rd_n),
        .wb     (wb),
        .hben   (db_in[BYTE_W]),
        .result (result_q),
        .tag    (tag_q),
        .db_out (db_out),
        .db_oe  (db_oe)
    );
endmodule

// File: rtl/adc_ctl_port_chk.sv
// Module: property checker for adc_ctl_port, attached with bind.
module adc_ctl_port_chk #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_n,
    input logic              conv_q,
    input logic              mclk_tick,
    input logic              busy,
    input logic              sample_hold,
    input logic              asleep,
    input logic              cs_n,
    input logic              rd_n,
    input logic              wb,
    input logic [DATA_W-1:0] db_in,
    input logic [DATA_W-1:0] db_out,
    input logic [DATA_W-1:0] db_oe
);
    // R2: an accepted falling edge enters hold and busy
    p_start_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_q && !conv_n && !busy && !asleep) |=> (busy && sample_hold));

    // R3: hold only within busy
    p_hold_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_hold |-> busy);

    // R3: without a tick the hold phase cannot end
    p_no_tick_keeps_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_hold && !mclk_tick && !(conv_q && !conv_n)) |=> sample_hold);

    // R3: busy falls exactly one edge after hold is released
    p_busy_after_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sample_hold) |=> !busy);

    // R8: no drive unless selected and reading
    p_bus_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> (db_oe == '0 && db_out == '0));

    // R7: padding bits of the high byte read zero
    p_hi_pad_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !rd_n && !wb && db_in[8]) |-> (db_out[7:6] == 2'b00));

    // R11: no conversion begins while asleep
    p_sleep_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && !busy) |=> !busy);
endmodule

bind adc_ctl_port adc_ctl_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .conv_n      (conv_n),
    .conv_q      (conv_q),
    .mclk_tick   (mclk_tick),
    .busy        (busy),
    .sample_hold (sample_hold),
    .asleep      (asleep),
    .cs_n        (cs_n),
    .rd_n        (rd_n),
    .wb          (wb),
    .db_in       (db_in),
    .db_out      (db_out),
    .db_oe       (db_oe)
);

// File: tb/adc_ctl_port_tb.sv
module adc_ctl_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mclk_tick = 1'b0;
    logic        conv_n = 1'b1;
    logic [11:0] result_in = '0;
    logic        wb = 1'b1;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [11:0] db_in = '0;
    logic [11:0] db_out;
    logic [11:0] db_oe;
    logic        busy;
    logic        sample_hold;
    logic        asleep;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    adc_ctl_port u_dut (
        .clk(clk), .rst_n(rst_n), .mclk_tick(mclk_tick), .conv_n(conv_n),
        .result_in(result_in), .wb(wb), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .db_in(db_in), .db_out(db_out), .db_oe(db_oe), .busy(busy),
        .sample_hold(sample_hold), .asleep(asleep)
    );

    function automatic logic [11:0] exp_hi(input logic [11:0] r, input logic [1:0] ch);
        return {4'b0, 2'b00, ch, r[11:8]};
    endfunction

    function automatic logic [11:0] exp_lo(input logic [11:0] r);
        return {4'b0, r[7:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_cycle(input logic mode_w, input logic [11:0] d, input logic cs);
        @(negedge clk);
        wb = mode_w; db_in = d; cs_n = cs; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1; wb = 1'b1; db_in = '0;
    endtask

    // read all three views and compare (R5, R6, R7)
    task automatic read_all(input logic [11:0] r, input logic [1:0] ch);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; wb = 1'b1; db_in = '0;
        #1;
        check("R5 word data", db_out, r);
        check("R5 word oe", db_oe, 12'hFFF);
        wb = 1'b0; db_in = 12'h000;
        #1;
        check("R6 low byte", db_out, exp_lo(r));
        check("R6 low oe", db_oe, 12'h0FF);
        db_in = 12'h100;
        #1;
        check("R7 high byte", db_out, exp_hi(r, ch));
        check("R7 high oe", db_oe, 12'h0FF);
        cs_n = 1'b1; rd_n = 1'b1; wb = 1'b1; db_in = '0;
    endtask

    // one conversion with random tick gaps; optional stray start pulse (R4)
    task automatic do_conv(input logic [11:0] r, input int tick_pct, input logic stray);
        int ticks = 0;
        int stray_at = 3 + ($urandom % 6);
        @(negedge clk);
        conv_n = 1'b1; result_in = r;
        @(negedge clk);
        conv_n = 1'b0;
        @(negedge clk);
        check("R2 busy on start", busy, 1'b1);
        check("R2 hold on start", sample_hold, 1'b1);
        conv_n = 1'b1;
        while (ticks < 13) begin
            mclk_tick = (($urandom % 100) < tick_pct);
            if (stray && ticks == stray_at) conv_n = ~conv_n;
            @(negedge clk);
            if (mclk_tick) ticks++;
            if (ticks < 13) begin
                check("R3/R4 still holding", {busy, sample_hold}, 2'b11);
            end else begin
                check("R3 track at 13th tick", {busy, sample_hold}, 2'b10);
            end
        end
        mclk_tick = 1'b0; conv_n = 1'b1;
        @(negedge clk);
        check("R3 busy low after track", busy, 1'b0);
    endtask

    initial begin
        logic [11:0] r;
        logic [1:0]  ch;
        void'($urandom(32'h5EED_0042));
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", busy, 1'b0);
        check("R1 hold", sample_hold, 1'b0);
        check("R1 asleep", asleep, 1'b0);
        check("R1 oe idle", db_oe, 12'h000);
        read_all(12'h000, 2'd0);

        // R8 bus quiet unless both strobes low
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b1; #1;
        check("R8 rd high oe", db_oe, 12'h000);
        check("R8 rd high data", db_out, 12'h000);
        cs_n = 1'b1; rd_n = 1'b0; #1;
        check("R8 cs high oe", db_oe, 12'h000);
        rd_n = 1'b1;

        // directed: full-scale result on channel 3 via word write (R9)
        wr_cycle(1'b1, 12'h003, 1'b0);
        do_conv(12'hFFF, 100, 1'b0);
        read_all(12'hFFF, 2'd3);

        // R12: write with cs_n high leaves channel 3
        wr_cycle(1'b1, 12'h001, 1'b1);
        do_conv(12'h5A3, 60, 1'b0);
        read_all(12'h5A3, 2'd3);

        // R10: byte-low write changes channel to 2
        wr_cycle(1'b0, 12'h002, 1'b0);
        do_conv(12'h0C7, 30, 1'b0);
        read_all(12'h0C7, 2'd2);

        // R4: stray start pulse during conversion is ignored
        do_conv(12'h81E, 50, 1'b1);
        read_all(12'h81E, 2'd2);

        // R10/R11: byte-high write sets auto-sleep (db_in[8]=1, db_in[0]=1)
        wr_cycle(1'b0, 12'h101, 1'b0);
        do_conv(12'h333, 70, 1'b0);
        check("R11 asleep at end", asleep, 1'b1);
        @(negedge clk); conv_n = 1'b0;
        cyc(3);
        check("R11 start ignored asleep", busy, 1'b0);
        check("R11 still asleep", asleep, 1'b1);
        conv_n = 1'b1;
        @(negedge clk);
        check("R11 woken by rising edge", asleep, 1'b0);

        // R10: high-byte write with nonzero upper nibble is dropped
        wr_cycle(1'b0, 12'h110, 1'b0);
        do_conv(12'h444, 80, 1'b0);
        check("R10 rejected write kept sleep", asleep, 1'b1);
        @(negedge clk); conv_n = 1'b0;
        @(negedge clk); conv_n = 1'b1;
        @(negedge clk);
        check("R11 wake again", asleep, 1'b0);

        // R10: valid high-byte write clears auto-sleep
        wr_cycle(1'b0, 12'h100, 1'b0);
        do_conv(12'h777, 80, 1'b0);
        check("R10 sleep cleared", asleep, 1'b0);
        read_all(12'h777, 2'd2);

        // random conversions with random channel, result and tick density
        for (int k = 0; k < 24; k++) begin
            r  = 12'($urandom);
            ch = 2'($urandom);
            if ($urandom % 2) wr_cycle(1'b1, {10'd0, ch}, 1'b0);
            else              wr_cycle(1'b0, {4'd0, 6'($urandom) & 6'h3C, ch}, 1'b0);
            do_conv(r, 20 + ($urandom % 81), ($urandom % 3) == 0);
            read_all(r, ch);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule